// File: doc/BRIEF.md
# Omega Memory Routing Network

This block carries request messages from eight processor ports to eight memory module ports through three layers of 2×2 switching elements. Each message holds a destination module number, an address inside that module, a one-bit opcode and a 32-bit write value, and it enters through a valid/ready handshake. No central controller is involved. Each layer rotates the port index left by one bit (a perfect shuffle) and then steers every message with one bit of its own module number, starting from the most significant bit. After the last layer, a message's position equals its destination.

Every switch output is a single register, so a message with no competition takes three cycles from the input handshake to the output port. Two messages may need the same switch output in the same cycle. In that case a round-robin arbiter for that output admits one of them. The other input holds its message with ready low until it wins. Downstream backpressure moves back through the registers toward the inputs, and no message is lost or duplicated.

Top module: `omega_net`

## Requirements
- R1: While reset is held, and after it is released with no input valid, every `out_valid_o` bit and every `in_ready_o` bit is 0.
- R2: A message whose 3-bit module field holds value d leaves only on output port d, and that port's `out_mod_o` slice shows d.
- R3: The address, the opcode (0 = READ, 1 = WRITE) and the data value reach the output exactly as they were presented at the input.
- R4: A message with no competition becomes visible on its output port three clock edges after the edge that accepted it, counting the accepting edge.
- R5: Each accepted message is delivered exactly once, for any pattern of destinations, including several inputs aimed at one module.
- R6: `in_ready_o[i]` is high only while `in_valid_i[i]` is high. A port that loses arbitration keeps ready low, and its held message is still delivered later.
- R7: For two inputs that compete for one switch output, grants alternate. After reset, the input on the switch's upper position wins first. Ports 0 and 4 sending a stream to module 0 therefore arrive in the order 0, 4, 0, 4, and so on.
- R8: For a conflict-free permutation (port i to module i), every input is accepted on consecutive cycles while all outputs are ready.
- R9: While `out_ready_i[p]` is low, `out_valid_o[p]` stays high and the whole payload on port p stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | N | Per-input message valid |
| in_ready_o | output | N | Per-input accept |
| in_mod_i | input | N*3 | Destination module number per input |
| in_addr_i | input | N*AW | Address within module per input |
| in_op_i | input | N | Opcode per input, 0 READ, 1 WRITE |
| in_data_i | input | N*DW | Write value per input |
| out_valid_o | output | N | Per-module message valid |
| out_ready_i | input | N | Per-module accept |
| out_mod_o | output | N*3 | Module number of the delivered message |
| out_addr_o | output | N*AW | Address of the delivered message |
| out_op_o | output | N | Opcode of the delivered message |
| out_data_o | output | N*DW | Write value of the delivered message |

## Verification
Contention at a switch and stalls caused by downstream backpressure can occur in the same cycle. This happens when a register holds a loser of arbitration while its own output is blocked. The bench provokes this case by sending all eight ports to one module while it toggles that module's ready every few cycles. Messages are tagged through the address field. The bench judges the result by the delivery count of each tag, by the route and payload of each tag, and by the hold properties on stalled outputs.

// File: rtl/omega_pkg.sv
`timescale 1ns/1ps
package omega_pkg;
  localparam int unsigned PORTS  = 8;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;

  // position in the previous level that feeds shuffled position pos
  function automatic int unsigned shuf_src(int unsigned pos, int unsigned bits);
    return (pos >> 1) | ((pos & 1) << (bits - 1));
  endfunction
endpackage

// File: rtl/omega_arb2.sv
`timescale 1ns/1ps
module omega_arb2 (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,
  input  logic       adv_i,
  output logic [1:0] gnt_o
);
  logic prio_q;

  always_comb begin
    if (&req_i) gnt_o = prio_q ? 2'b10 : 2'b01;
    else        gnt_o = req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                prio_q <= 1'b0;
    else if (adv_i && (&req_i)) prio_q <= ~gnt_o[1];
  end
endmodule

// File: rtl/omega_switch.sv
`timescale 1ns/1ps
module omega_switch #(
  parameter int unsigned MSG_W   = 52,
  parameter int unsigned SEL_BIT = 51
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       in_v_i,
  input  logic [MSG_W-1:0] in_m_i [2],
  output logic [1:0]       in_r_o,
  output logic [1:0]       out_v_o,
  output logic [MSG_W-1:0] out_m_o [2],
  input  logic [1:0]       out_r_i
);
  logic [1:0] acc;
  logic [1:0] gnt [2];

  for (genvar o = 0; o < 2; o++) begin : g_out
    logic [1:0]       req;
    logic             v_q;
    logic [MSG_W-1:0] m_q;

    for (genvar i = 0; i < 2; i++) begin : g_req
      assign req[i] = in_v_i[i] && (in_m_i[i][SEL_BIT] == 1'(o));
    end

    // register may load when empty or when its content leaves this cycle
    assign acc[o] = !v_q || out_r_i[o];

    omega_arb2 u_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (req),
      .adv_i (acc[o]),
      .gnt_o (gnt[o])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        m_q <= '0;
      end else if (acc[o]) begin
        v_q <= |req;
        if (|req) m_q <= gnt[o][1] ? in_m_i[1] : in_m_i[0];
      end
    end

    assign out_v_o[o] = v_q;
    assign out_m_o[o] = m_q;
  end

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      in_r_o[i] = (gnt[0][i] && acc[0]) || (gnt[1][i] && acc[1]);
    end
  end
endmodule

// File: rtl/omega_net.sv
`timescale 1ns/1ps
module omega_net
  import omega_pkg::*;
#(
  parameter  int unsigned N  = PORTS,
  parameter  int unsigned AW = ADDR_W,
  parameter  int unsigned DW = DATA_W,
  localparam int unsigned MW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]    in_valid_i,
  output logic [N-1:0]    in_ready_o,
  input  logic [N*MW-1:0] in_mod_i,
  input  logic [N*AW-1:0] in_addr_i,
  input  logic [N-1:0]    in_op_i,
  input  logic [N*DW-1:0] in_data_i,
  output logic [N-1:0]    out_valid_o,
  input  logic [N-1:0]    out_ready_i,
  output logic [N*MW-1:0] out_mod_o,
  output logic [N*AW-1:0] out_addr_o,
  output logic [N-1:0]    out_op_o,
  output logic [N*DW-1:0] out_data_o
);
  localparam int unsigned STAGES = MW;
  localparam int unsigned MSG_W  = MW + AW + 1 + DW;

  // message layout: {mod, addr, op, data}; mod on top so stage s reads bit MSG_W-1-s
  wire [N-1:0]     v_l [STAGES+1];
  wire [N-1:0]     r_l [STAGES+1];
  wire [MSG_W-1:0] m_l [STAGES+1][N];

  assign v_l[0]      = in_valid_i;
  assign in_ready_o  = r_l[0];
  assign out_valid_o = v_l[STAGES];
  assign r_l[STAGES] = out_ready_i;

  for (genvar p = 0; p < N; p++) begin : g_io
    assign m_l[0][p] = {in_mod_i[p*MW +: MW], in_addr_i[p*AW +: AW],
                        in_op_i[p], in_data_i[p*DW +: DW]};
    assign {out_mod_o[p*MW +: MW], out_addr_o[p*AW +: AW],
            out_op_o[p], out_data_o[p*DW +: DW]} = m_l[STAGES][p];
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    for (genvar j = 0; j < N/2; j++) begin : g_sw
      localparam int unsigned SRC_A = shuf_src(2*j,   MW);
      localparam int unsigned SRC_B = shuf_src(2*j+1, MW);
      logic [MSG_W-1:0] sm_in  [2];
      logic [MSG_W-1:0] sm_out [2];
      logic [1:0]       sv_out;
      logic [1:0]       s_rdy;

      assign sm_in[0] = m_l[s][SRC_A];
      assign sm_in[1] = m_l[s][SRC_B];

      omega_switch #(
        .MSG_W  (MSG_W),
        .SEL_BIT(MSG_W - 1 - s)
      ) u_sw (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .in_v_i ({v_l[s][SRC_B], v_l[s][SRC_A]}),
        .in_m_i (sm_in),
        .in_r_o (s_rdy),
        .out_v_o(sv_out),
        .out_m_o(sm_out),
        .out_r_i({r_l[s+1][2*j+1], r_l[s+1][2*j]})
      );

      assign r_l[s][SRC_A]     = s_rdy[0];
      assign r_l[s][SRC_B]     = s_rdy[1];
      assign v_l[s+1][2*j]     = sv_out[0];
      assign v_l[s+1][2*j+1]   = sv_out[1];
      assign m_l[s+1][2*j]     = sm_out[0];
      assign m_l[s+1][2*j+1]   = sm_out[1];
    end
  end
endmodule

// File: rtl/omega_net_chk.sv
`timescale 1ns/1ps
module omega_net_chk #(
  parameter  int unsigned N  = 8,
  parameter  int unsigned AW = 16,
  parameter  int unsigned DW = 32,
  localparam int unsigned MW = $clog2(N)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]    in_valid_i,
  input logic [N-1:0]    in_ready_o,
  input logic [N-1:0]    out_valid_o,
  input logic [N-1:0]    out_ready_i,
  input logic [N*MW-1:0] out_mod_o,
  input logic [N*AW-1:0] out_addr_o,
  input logic [N-1:0]    out_op_o,
  input logic [N*DW-1:0] out_data_o
);
  for (genvar p = 0; p < N; p++) begin : g_port
    p_route_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[p] |-> (out_mod_o[p*MW +: MW] == MW'(p)));

    p_hold_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[p] && !out_ready_i[p]) |=> out_valid_o[p]);

    p_hold_payload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[p] && !out_ready_i[p]) |=>
        ($stable(out_addr_o[p*AW +: AW]) && $stable(out_data_o[p*DW +: DW]) &&
         $stable(out_op_o[p]) && $stable(out_mod_o[p*MW +: MW])));

    p_ready_needs_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_ready_o[p] |-> in_valid_i[p]);
  end
endmodule

bind omega_net omega_net_chk #(.N(N), .AW(AW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_mod_o  (out_mod_o),
  .out_addr_o (out_addr_o),
  .out_op_o   (out_op_o),
  .out_data_o (out_data_o)
);

// File: tb/tb_omega_net.sv
`timescale 1ns/1ps
module tb_omega_net;
  localparam int N  = 8;
  localparam int MW = 3;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int MAXT = 1024;

  // each entry: module number for input i at bits [3*i +: 3]
  localparam logic [23:0] PERM_TBL [8] = '{
    {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0},  // identity
    {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7},  // reversal
    {3'd0,3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1},  // rotate by one
    {3'd3,3'd3,3'd3,3'd3,3'd3,3'd3,3'd3,3'd3},  // hotspot
    {3'd6,3'd7,3'd4,3'd5,3'd2,3'd3,3'd0,3'd1},  // swap neighbours
    {3'd3,3'd2,3'd1,3'd0,3'd7,3'd6,3'd5,3'd4},  // swap halves
    {3'd7,3'd3,3'd5,3'd1,3'd6,3'd2,3'd4,3'd0},  // bit reversal
    {3'd7,3'd0,3'd7,3'd0,3'd7,3'd0,3'd7,3'd0}   // two hotspots
  };

  logic          clk;
  logic          rst_n;
  logic [N-1:0]    in_valid;
  logic [N-1:0]    in_ready;
  logic [N*MW-1:0] in_mod;
  logic [N*AW-1:0] in_addr;
  logic [N-1:0]    in_op;
  logic [N*DW-1:0] in_data;
  logic [N-1:0]    out_valid;
  logic [N-1:0]    out_ready;
  logic [N*MW-1:0] out_mod;
  logic [N*AW-1:0] out_addr;
  logic [N-1:0]    out_op;
  logic [N*DW-1:0] out_data;

  omega_net dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_mod_i(in_mod), .in_addr_i(in_addr), .in_op_i(in_op), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_mod_o(out_mod), .out_addr_o(out_addr), .out_op_o(out_op), .out_data_o(out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int q [N][$];
  bit fired [N];
  int exp_dest [MAXT];
  int dcnt     [MAXT];
  int fire_cyc [MAXT];
  int seen_cyc [MAXT];
  int log0 [$];
  int cyc = 0, checks = 0, errors = 0, next_tag = 0;
  bit hold_out = 1'b0;
  bit done = 1'b0;

  function automatic logic [DW-1:0] data_of(int t);
    return DW'(t) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic op_of(int t);
    return 1'(t % 2);  // 0 READ, 1 WRITE
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic enqueue(int src, int mod);
    exp_dest[next_tag] = mod;
    q[src].push_back(next_tag);
    next_tag++;
  endtask

  // driver and monitor, both away from the rising edge
  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < N; i++) begin
      if (fired[i]) void'(q[i].pop_front());
      fired[i] = 1'b0;
    end
    for (int i = 0; i < N; i++) begin
      if (q[i].size() > 0) begin
        in_valid[i]           = 1'b1;
        in_mod[i*MW +: MW]    = MW'(exp_dest[q[i][0]]);
        in_addr[i*AW +: AW]   = AW'(q[i][0]);
        in_op[i]              = op_of(q[i][0]);
        in_data[i*DW +: DW]   = data_of(q[i][0]);
      end else begin
        in_valid[i] = 1'b0;
      end
    end
    out_ready = hold_out ? '0 : '1;
    #1;
    for (int i = 0; i < N; i++) begin
      fired[i] = in_valid[i] && in_ready[i];
      if (fired[i]) fire_cyc[q[i][0]] = cyc;
    end
    for (int p = 0; p < N; p++) begin
      if (out_valid[p]) begin
        int t;
        t = int'(out_addr[p*AW +: AW]);
        if (t >= MAXT) begin
          chk(1'b0, "R3 tag range", t, 0);
        end else begin
          if (seen_cyc[t] < 0) seen_cyc[t] = cyc;
          if (out_ready[p]) begin
            chk(int'(out_mod[p*MW +: MW]) == p, "R2 mod field", int'(out_mod[p*MW +: MW]), p);
            chk(exp_dest[t] == p, "R2 port", p, exp_dest[t]);
            chk(out_op[p] == op_of(t), "R3 opcode", int'(out_op[p]), int'(op_of(t)));
            chk(out_data[p*DW +: DW] == data_of(t), "R3 data",
                int'(out_data[p*DW +: DW]), int'(data_of(t)));
            dcnt[t]++;
            if (p == 0) log0.push_back(t);
          end
        end
      end
    end
  end

  task automatic wait_drain();
    int idle;
    idle = 0;
    for (int k = 0; k < 3000 && idle < 5; k++) begin
      bit busy;
      @(negedge clk); #2;
      busy = (out_valid != '0);
      for (int i = 0; i < N; i++) busy = busy || (q[i].size() > 0) || fired[i];
      idle = busy ? 0 : idle + 1;
    end
  endtask

  task automatic verify_once(int a, int b, string req);
    for (int t = a; t < b; t++) chk(dcnt[t] == 1, req, dcnt[t], 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int st;
    for (int t = 0; t < MAXT; t++) begin
      seen_cyc[t] = -1; dcnt[t] = 0; fire_cyc[t] = -1; exp_dest[t] = 0;
    end
    in_valid = '0; in_mod = '0; in_addr = '0; in_op = '0; in_data = '0;
    out_ready = '1;
    rst_n = 1'b0;

    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    chk(out_valid == '0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == '0, "R1 in_ready in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    chk(out_valid == '0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == '0, "R1/R6 in_ready without valid", int'(in_ready), 0);

    // R2 R3 R5: table of destination patterns
    for (int pi = 0; pi < 8; pi++) begin
      st = next_tag;
      for (int i = 0; i < N; i++) enqueue(i, int'(PERM_TBL[pi][3*i +: 3]));
      wait_drain();
      verify_once(st, next_tag, "R5 pattern delivery");
    end

    // R4: uncontested latency on two different routes
    st = next_tag;
    enqueue(3, 5);
    wait_drain();
    enqueue(6, 1);
    wait_drain();
    for (int t = st; t < st + 2; t++)
      chk(seen_cyc[t] - fire_cyc[t] == 3, "R4 latency", seen_cyc[t] - fire_cyc[t], 3);

    // R8: back-to-back identity stream
    st = next_tag;
    for (int w = 0; w < 4; w++)
      for (int i = 0; i < N; i++) enqueue(i, i);
    wait_drain();
    for (int i = 0; i < N; i++)
      for (int w = 1; w < 4; w++)
        chk(fire_cyc[st+w*8+i] - fire_cyc[st+(w-1)*8+i] == 1, "R8 accept spacing",
            fire_cyc[st+w*8+i] - fire_cyc[st+(w-1)*8+i], 1);
    verify_once(st, next_tag, "R5 stream delivery");

    // R7 R6: ports 0 and 4 compete for the first-stage upper output
    do_reset();
    log0.delete();
    st = next_tag;
    for (int k = 0; k < 4; k++) enqueue(0, 0);
    for (int k = 0; k < 4; k++) enqueue(4, 0);
    wait_drain();
    chk(log0.size() == 8, "R7 arrivals", log0.size(), 8);
    for (int k = 0; k < 8 && k < log0.size(); k++) begin
      int e;
      e = (k % 2 == 0) ? st + k/2 : st + 4 + k/2;
      chk(log0[k] == e, "R7 grant order", log0[k], e);
    end
    chk(fire_cyc[st+4] == fire_cyc[st] + 1, "R6 loser held one cycle",
        fire_cyc[st+4], fire_cyc[st] + 1);
    verify_once(st, next_tag, "R6 held messages delivered");

    // R9: outputs blocked, then released
    hold_out = 1'b1;
    st = next_tag;
    for (int i = 0; i < N; i++) enqueue(i, i);
    repeat (12) @(negedge clk);
    #2;
    chk(out_valid == '1, "R9 valid held", int'(out_valid), 255);
    for (int p = 0; p < N; p++)
      chk(int'(out_addr[p*AW +: AW]) == st + p, "R9 payload", int'(out_addr[p*AW +: AW]), st + p);
    for (int i = 0; i < N; i++) enqueue(i, i);
    repeat (6) @(negedge clk);
    #2;
    chk(out_valid == '1, "R9 valid still held", int'(out_valid), 255);
    for (int p = 0; p < N; p++) begin
      chk(int'(out_addr[p*AW +: AW]) == st + p, "R9 payload stable",
          int'(out_addr[p*AW +: AW]), st + p);
      chk(dcnt[st+p] == 0, "R9 nothing taken", dcnt[st+p], 0);
    end
    hold_out = 1'b0;
    wait_drain();
    verify_once(st, next_tag, "R5 after backpressure");

    // R5 R6 R9: hotspot under toggling backpressure
    st = next_tag;
    for (int i = 0; i < N; i++) enqueue(i, 3);
    for (int k = 0; k < 10; k++) begin
      hold_out = ~hold_out;
      repeat (3) @(negedge clk);
    end
    hold_out = 1'b0;
    wait_drain();
    verify_once(st, next_tag, "R5 hotspot with stalls");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(negedge clk) begin
    if (!done && cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule